// File: doc/BRIEF.md
# Signal Quality Flag Generator

This block turns the per-symbol mean-squared error reported by a receiver's decision stage into a one-bit, active-low quality flag. It does not compute the error itself. It smooths the error with a leaky running average and compares the average against one of four selectable compare constants. From that comparison it drives one of three patterns on the flag:

- **Steady low:** the link is good.
- **Square wave with a fixed half-period:** the average has crossed the chosen level.
- **Steady high:** the demodulator reports loss of convergence and a retrain is needed.

The flag only carries meaning for the two modulation families that have a decision error: QAM and DPSK. In every other mode the block parks the flag low and clears its internal state.

A host samples the flag as a coarse link-health indicator. A typical use is counting the toggles or detecting a constant high to decide when to retrain.

Top module: `sqi_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sqi_o` is 0. The error average and the toggle counter restart from zero.
- R2: The mode is qualified and `lost_i` is 0. If the averaged error on a clock edge is not greater than the selected compare constant, `sqi_o` is 0 after that edge.
- R3: On each edge where the mode is qualified and `err_vld_i` is 1, the accumulator A becomes A − (A >> 4) + `err_i`. The averaged error is A >> 4. Without `err_vld_i`, A holds its value.
- R4: `thr_sel_i` picks the compare constant from `THR_TABLE` (slot n = bits [16n+15:16n]). The codes map to error-rate levels as follows:

  | `thr_sel_i` | Error-rate level | Default constant |
  |---|---|---|
  | 00 (reset-time default use) | 1e-5 | 0x0400 |
  | 01 | 1e-6 | 0x0200 |
  | 10 | 1e-4 | 0x0800 |
  | 11 | 1e-3 | 0x1000 |

  "Above" means the average is strictly greater than the constant.
- R5: The mode is qualified, `lost_i` is 0, and the average is above. A cycle counter then advances each edge. On the edge where it reaches `TOGGLE_CYCLES`−1, `sqi_o` inverts and the counter restarts. This gives one inversion every `TOGGLE_CYCLES` clocks.
- R6: With the mode qualified, `lost_i` = 1 forces `sqi_o` to 1 on the next edge and clears the counter. This takes priority over the toggle timing.
- R7: `mode_i` encodings are 00 FSK, 01 DPSK, 10 QAM and 11 reserved. Only 01 and 10 are qualified. In any other code, `sqi_o` is 0 after the next edge and the counter and the accumulator are cleared.
- R8: The average falls back to or below the constant while `lost_i` = 0. `sqi_o` then returns low on the next edge. A later crossing waits a full `TOGGLE_CYCLES` before its first inversion.
- R9: `lost_i` is released while the average is still above. Toggling then resumes from the high level, with a full `TOGGLE_CYCLES` before the first inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Modulation family (00 FSK, 01 DPSK, 10 QAM, 11 reserved) |
| err_vld_i | input | 1 | Strobe marking a new per-symbol error value |
| err_i | input | ERR_W | Per-symbol mean-squared error |
| thr_sel_i | input | 2 | Compare level select |
| lost_i | input | 1 | Loss of convergence from the demodulator |
| sqi_o | output | 1 | Registered quality flag, low means good |

## Verification
Two events can land on the same edge:

- **Loss of convergence and toggle expiry:** `lost_i` can rise on the very edge where the toggle counter expires. The flag must then read high, not inverted, and the next inversion must wait a fresh full period.
- **Mode change and error strobe:** the mode can leave the qualified set on the same edge as a valid error strobe. The accumulator must then be cleared rather than updated.

Random stimulus provokes both collisions. It mixes short loss pulses and mode flips into long stretches of above-level errors. A bench model, written from the requirements, judges the flag on every cycle.

// File: rtl/sqi_pkg.sv
package sqi_pkg;

  typedef enum logic [1:0] {
    MOD_FSK  = 2'b00,
    MOD_DPSK = 2'b01,
    MOD_QAM  = 2'b10,
    MOD_RSVD = 2'b11
  } mod_e;

  typedef enum logic [1:0] {
    ST_GOOD   = 2'b00,
    ST_TOGGLE = 2'b01,
    ST_LOST   = 2'b10
  } sqi_state_e;

  function automatic logic mode_qualified(input logic [1:0] m);
    return (m == MOD_DPSK) || (m == MOD_QAM);
  endfunction

endpackage

// File: rtl/sqi_mse_avg.sv
module sqi_mse_avg #(
  parameter int ERR_W     = 16,
  parameter int AVG_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [ERR_W-1:0] avg_o
);

  localparam int ACC_W = ERR_W + AVG_SHIFT;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_leak;
  logic [ACC_W-1:0] acc_nxt;

  // Leaky integrator: steady state equals err << AVG_SHIFT, so ACC_W never overflows.
  always_comb begin
    acc_leak = acc_q >> AVG_SHIFT;
    acc_nxt  = acc_q - acc_leak + ACC_W'(err_i);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
    end else if (vld_i) begin
      acc_q <= acc_nxt;
    end
  end

  assign avg_o = acc_q[ACC_W-1:AVG_SHIFT];

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld_i && !clr_i) |=> $stable(acc_q));

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_q == '0));

endmodule

// File: rtl/sqi_thr_cmp.sv
module sqi_thr_cmp #(
  parameter int                 ERR_W     = 16,
  parameter int                 N_LEVELS  = 4,
  parameter int                 SEL_W     = $clog2(N_LEVELS),
  parameter logic [N_LEVELS*ERR_W-1:0] THR_TABLE = {16'h1000, 16'h0800, 16'h0200, 16'h0400}
) (
  input  logic [ERR_W-1:0] avg_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             above_o
);

  logic [ERR_W-1:0] thr_tab [N_LEVELS];
  logic [N_LEVELS-1:0] over_vec;

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
    assign thr_tab[g]  = THR_TABLE[g*ERR_W +: ERR_W];
    assign over_vec[g] = (avg_i > thr_tab[g]);
  end

  assign above_o = over_vec[sel_i];

endmodule

// File: rtl/sqi_toggle_ctl.sv
module sqi_toggle_ctl
  import sqi_pkg::*;
#(
  parameter int TOGGLE_CYCLES = 83000,
  parameter int CNT_W         = (TOGGLE_CYCLES > 2) ? $clog2(TOGGLE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  input  logic lost_i,
  input  logic above_i,
  output logic flag_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOGGLE_CYCLES - 1);

  sqi_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (!qual_i) begin
      st_d   = ST_GOOD;
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (lost_i) begin
      st_d   = ST_LOST;
      cnt_d  = '0;
      flag_d = 1'b1;
    end else if (above_i) begin
      st_d = ST_TOGGLE;
      if (cnt_q == CNT_LAST) begin
        cnt_d  = '0;
        flag_d = ~flag_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      st_d   = ST_GOOD;
      cnt_d  = '0;
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_GOOD;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);

  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_i && !lost_i && above_i && cnt_q != CNT_LAST) |=> $stable(flag_o));

  // R6
  lost_high_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_i && lost_i) |=> (flag_o && st_q == ST_LOST));

  // R7
  unqual_low_chk: assert property (@(posedge clk) disable iff (rst)
    !qual_i |=> (!flag_o && cnt_q == '0));

  // R2
  good_low_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_i && !lost_i && !above_i) |=> (!flag_o && st_q == ST_GOOD));

endmodule

// File: rtl/sqi_gen.sv
module sqi_gen
  import sqi_pkg::*;
#(
  parameter int ERR_W         = 16,
  parameter int AVG_SHIFT     = 4,
  parameter int TOGGLE_CYCLES = 83000,
  parameter logic [4*ERR_W-1:0] THR_TABLE = {16'h1000, 16'h0800, 16'h0200, 16'h0400}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             err_vld_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [1:0]       thr_sel_i,
  input  logic             lost_i,
  output logic             sqi_o
);

  logic             qual;
  logic [ERR_W-1:0] avg;
  logic             above;

  assign qual = mode_qualified(mode_i);

  sqi_mse_avg #(
    .ERR_W     (ERR_W),
    .AVG_SHIFT (AVG_SHIFT)
  ) u_avg (
    .clk   (clk),
    .rst   (rst),
    .clr_i (!qual),
    .vld_i (err_vld_i),
    .err_i (err_i),
    .avg_o (avg)
  );

  sqi_thr_cmp #(
    .ERR_W     (ERR_W),
    .N_LEVELS  (4),
    .SEL_W     (2),
    .THR_TABLE (THR_TABLE)
  ) u_cmp (
    .avg_i   (avg),
    .sel_i   (thr_sel_i),
    .above_o (above)
  );

  sqi_toggle_ctl #(
    .TOGGLE_CYCLES (TOGGLE_CYCLES)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .qual_i  (qual),
    .lost_i  (lost_i),
    .above_i (above),
    .flag_o  (sqi_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !sqi_o);

endmodule

// File: tb/sqi_gen_tb.sv
module sqi_gen_tb;

  localparam int TOG = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'b10;
  logic        err_vld_i = 1'b0;
  logic [15:0] err_i = '0;
  logic [1:0]  thr_sel_i = 2'b00;
  logic        lost_i = 1'b0;
  logic        sqi_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sqi_gen #(.TOGGLE_CYCLES(TOG)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .err_vld_i(err_vld_i),
    .err_i(err_i), .thr_sel_i(thr_sel_i), .lost_i(lost_i), .sqi_o(sqi_o)
  );

  function automatic logic [15:0] thr_of(input logic [1:0] s);
    case (s)
      2'b00: return 16'h0400;
      2'b01: return 16'h0200;
      2'b10: return 16'h0800;
      default: return 16'h1000;
    endcase
  endfunction

  // Reference model built from the requirements
  logic [19:0] m_acc = '0;
  int          m_cnt = 0;
  logic        m_flag = 1'b0;

  always @(posedge clk) begin
    logic q, above;
    if (rst) begin
      m_acc = '0; m_cnt = 0; m_flag = 1'b0;
    end else begin
      q = (mode_i == 2'b01) || (mode_i == 2'b10);
      above = (m_acc >> 4) > {4'b0, thr_of(thr_sel_i)};
      if (!q) begin m_flag = 1'b0; m_cnt = 0; end
      else if (lost_i) begin m_flag = 1'b1; m_cnt = 0; end
      else if (above) begin
        if (m_cnt == TOG-1) begin m_flag = ~m_flag; m_cnt = 0; end
        else m_cnt++;
      end else begin m_flag = 1'b0; m_cnt = 0; end
      if (!q) m_acc = '0;
      else if (err_vld_i) m_acc = m_acc - (m_acc >> 4) + {4'b0, err_i};
    end
  end

  task automatic cyc(input string tag);
    @(negedge clk);
    checks++;
    if (sqi_o !== m_flag) begin
      failures++;
      $display("FAIL %s t=%0t sqi_o actual=%b expected=%b", tag, $time, sqi_o, m_flag);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    run(3, "R1");
    @(negedge clk); rst = 1'b0;
    run(2, "R1");
    // R2: good link stays low
    err_vld_i = 1'b1; err_i = 16'h0100;
    run(40, "R2");
    // R5 and R4: high error crosses level 00, toggling
    err_i = 16'h3000;
    run(80, "R5");
    // R6: loss of convergence
    lost_i = 1'b1;
    run(15, "R6");
    // R9: release with average still above
    lost_i = 1'b0;
    run(40, "R9");
    // R8: error falls, flag returns low
    err_i = 16'h0000;
    run(90, "R8");
    err_i = 16'h3000;
    run(50, "R8");
    // R4: level sweep with moderate error 0x0600
    err_i = 16'h0600;
    run(60, "R4");
    for (int s = 0; s < 4; s++) begin
      thr_sel_i = 2'(s);
      run(40, "R4");
    end
    // R3: strobe low, large error ignored
    thr_sel_i = 2'b10;
    err_vld_i = 1'b0; err_i = 16'hFFFF;
    run(40, "R3");
    // R7: unqualified modes
    err_vld_i = 1'b1; err_i = 16'h4000; mode_i = 2'b01;
    run(60, "R7");
    mode_i = 2'b00; run(20, "R7");
    mode_i = 2'b11; lost_i = 1'b1; run(20, "R7");
    lost_i = 1'b0; mode_i = 2'b10; run(20, "R7");
    // Random mix: loss pulses and mode flips over above-level toggling
    for (int i = 0; i < 4000; i++) begin
      err_vld_i = ($urandom % 4) != 0;
      err_i     = 16'($urandom % 16'h1400);
      if ($urandom % 200 == 0) thr_sel_i = 2'($urandom);
      lost_i    = ($urandom % 40) == 0;
      mode_i    = (($urandom % 150) == 0) ? 2'($urandom) :
                  (mode_i == 2'b00 || mode_i == 2'b11) ? 2'b10 : mode_i;
      if ($urandom % 50 == 0) rst = 1'b1; else rst = 1'b0;
      cyc("R5");
    end
    rst = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule